// File: doc/BRIEF.md
# Serial Receive Queue with Per-Character Error Tracking

This block sits between the deserializer of a 16550-style serial port and its register bank. Every character the deserializer hands over is stored with its own break, framing and parity flags. The register bank reads the oldest character, and that character's flags, from the head. The block reports when data is waiting and when the fill has reached a trigger level chosen by a 2-bit code. It also keeps two status bits: a sticky "some stored character is in error" bit and an overrun bit. When characters sit unread for too long, a character-timeout flag is raised.

With the queue enabled it holds 64 characters. With it disabled it behaves as a single holding register whose trigger level is always one. Software can flush the queue with a one-cycle clear pulse. Changing the enable also flushes it.

Top module: `uart_rxq`

## Requirements
- R1: After reset the block is empty: `data_ready`, `trig_hit`, `err_any`, `overrun` and `char_tout` are 0, and the head outputs are 0.
- R2: Characters leave in arrival order. While a character is at the head, `head_data`, `head_brk`, `head_fe` and `head_pe` show its stored byte and flags. An empty block shows zeros on all of them.
- R3: `data_ready` is 1 exactly when at least one character is stored.
- R4: With `fifo_en`=1, `trig_sel` selects the level: 2'b00 is 1, 2'b01 is 8, 2'b10 is 16 and 2'b11 is 14 characters. `trig_hit` is 1 while the number stored is at or above that level.
- R5: With `fifo_en`=0 the block holds at most one character, and `trig_hit` equals `data_ready` (the level is 1).
- R6: A `push_valid` that arrives while the block is at capacity, with no pop in the same cycle, drops the character and sets `overrun`. A push and a pop in the same cycle at capacity both take effect.
- R7: `lsr_read` clears `overrun` on the following edge. If a drop happens in the same cycle, the set wins.
- R8: `err_any` is 1 while any stored character has any of its three flags set. It clears only when the last such character has been popped.
- R9: `rx_clear` empties the block, clears `err_any` and `char_tout`, and discards any push or pop in the same cycle. It leaves `overrun` unchanged.
- R10: Any change of `fifo_en` empties the block in the same way as `rx_clear`.
- R11: `char_tout` rises after `tout_limit` consecutive cycles in which the block is non-empty with no accepted push and no pop. A limit of 0 acts as 1. It clears on the next pop or on a flush.
- R12: A pop while empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Deserializer delivers a character this cycle |
| push_data | input | 8 | Received byte |
| push_brk | input | 1 | Break seen on this character |
| push_fe | input | 1 | Framing error on this character |
| push_pe | input | 1 | Parity error on this character |
| pop | input | 1 | Register bank consumes the head character |
| fifo_en | input | 1 | 1: 64-entry queue, 0: single holding register |
| rx_clear | input | 1 | One-cycle flush request |
| trig_sel | input | 2 | Trigger level code |
| lsr_read | input | 1 | Line-status read strobe, clears overrun |
| tout_limit | input | 16 | Idle cycles before character timeout |
| head_data | output | 8 | Byte at the head |
| head_brk | output | 1 | Break flag of the head character |
| head_fe | output | 1 | Framing flag of the head character |
| head_pe | output | 1 | Parity flag of the head character |
| data_ready | output | 1 | At least one character stored |
| trig_hit | output | 1 | Fill at or above the trigger level |
| err_any | output | 1 | Some stored character carries an error |
| overrun | output | 1 | A character was dropped |
| char_tout | output | 1 | Character timeout |

## Verification
On every cycle the assertions check the following:
- the fill bound, including single-register mode;
- overrun setting after a drop and clearing after a status read;
- the empty state that follows a flush;
- that an erroneous head character implies `err_any`;
- that the timeout clears after a pop.

Arrival order, the exact trigger thresholds for each code, and the point at which `err_any` falls can only be shown by the bench's scenarios. Its reference queue tracks these across random push and pop mixes. The same goes for the timeout's exact cycle count and for the flush that follows a change of `fifo_en`.

// File: rtl/uart_rxq_pkg.sv
`timescale 1ns/1ps
package uart_rxq_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;

  // Trigger level for a select code; the single-register mode always uses 1.
  function automatic int unsigned trig_level(input logic [1:0] sel, input logic en);
    if (!en) return 1;
    case (sel)
      2'b00:   return 1;
      2'b01:   return 8;
      2'b10:   return 16;
      default: return 14;
    endcase
  endfunction

  function automatic logic entry_has_err(input rxq_entry_t e);
    return e.brk | e.fe | e.pe;
  endfunction
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_acc,
  input  logic             pop_fire,
  input  rxq_entry_t       wr_entry,
  output rxq_entry_t       head_entry,
  output logic [CNT_W-1:0] occupancy
);
  rxq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occupancy <= '0;
    end else if (flush) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occupancy <= '0;
    end else begin
      if (push_acc) wr_ptr <= wr_ptr + 1'b1;
      if (pop_fire) rd_ptr <= rd_ptr + 1'b1;
      case ({push_acc, pop_fire})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
    end
  end

  assign head_entry = (occupancy != '0) ? mem[rd_ptr] : '0;
endmodule

// File: rtl/rxq_err_track.sv
`timescale 1ns/1ps
module rxq_err_track #(
  parameter int unsigned CNT_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic push_acc,
  input  logic push_err,
  input  logic pop_fire,
  input  logic pop_err,
  output logic err_any
);
  logic [CNT_W-1:0] err_cnt;
  logic             inc, dec;

  assign inc = push_acc & push_err;
  assign dec = pop_fire & pop_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_cnt <= '0;
    else if (flush)      err_cnt <= '0;
    else if (inc & ~dec) err_cnt <= err_cnt + 1'b1;
    else if (dec & ~inc) err_cnt <= err_cnt - 1'b1;
  end

  assign err_any = (err_cnt != '0);
endmodule

// File: rtl/rxq_timeout.sv
`timescale 1ns/1ps
module rxq_timeout #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          nonempty,
  input  logic          push_acc,
  input  logic          pop_fire,
  input  logic [TW-1:0] limit,
  output logic          tout
);
  logic [TW-1:0] tcnt;
  logic [TW:0]   eff_limit, next_cnt;
  logic          idle, reach;

  assign idle      = nonempty & ~push_acc & ~pop_fire;
  assign eff_limit = (limit == '0) ? (TW+1)'(1) : {1'b0, limit};
  assign next_cnt  = {1'b0, tcnt} + 1'b1;
  assign reach     = (next_cnt >= eff_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      tout <= 1'b0;
    end else if (flush) begin
      tcnt <= '0;
      tout <= 1'b0;
    end else begin
      if (pop_fire)           tout <= 1'b0;
      else if (idle && reach) tout <= 1'b1;
      if (!idle)              tcnt <= '0;
      else if (~&tcnt)        tcnt <= tcnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_rxq.sv
`timescale 1ns/1ps
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned TOUT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_brk,
  input  logic              push_fe,
  input  logic              push_pe,
  input  logic              pop,
  input  logic              fifo_en,
  input  logic              rx_clear,
  input  logic [1:0]        trig_sel,
  input  logic              lsr_read,
  input  logic [TOUT_W-1:0] tout_limit,
  output logic [DATA_W-1:0] head_data,
  output logic              head_brk,
  output logic              head_fe,
  output logic              head_pe,
  output logic              data_ready,
  output logic              trig_hit,
  output logic              err_any,
  output logic              overrun,
  output logic              char_tout
);
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

  // Named internal events, also observed by the bound checker.
  logic [CNT_W-1:0] occupancy;
  logic [CNT_W-1:0] cap;
  logic             full, pop_fire, push_acc, drop, flush, en_q;
  rxq_entry_t       wr_entry, head_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= fifo_en;
  end

  assign flush    = rx_clear | (fifo_en != en_q);
  assign cap      = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full     = (occupancy >= cap);
  assign pop_fire = pop & (occupancy != '0) & ~flush;
  assign push_acc = push_valid & (~full | pop_fire) & ~flush;
  assign drop     = push_valid & ~push_acc & ~flush;
  assign wr_entry = '{brk: push_brk, fe: push_fe, pe: push_pe, data: push_data};

  rxq_store #(.DEPTH(DEPTH)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .push_acc   (push_acc),
    .pop_fire   (pop_fire),
    .wr_entry   (wr_entry),
    .head_entry (head_entry),
    .occupancy  (occupancy)
  );

  rxq_err_track #(.CNT_W(CNT_W)) err_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push_acc (push_acc),
    .push_err (entry_has_err(wr_entry)),
    .pop_fire (pop_fire),
    .pop_err  (entry_has_err(head_entry)),
    .err_any  (err_any)
  );

  rxq_timeout #(.TW(TOUT_W)) tout_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .nonempty (occupancy != '0),
    .push_acc (push_acc),
    .pop_fire (pop_fire),
    .limit    (tout_limit),
    .tout     (char_tout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        overrun <= 1'b0;
    else if (drop)     overrun <= 1'b1;
    else if (lsr_read) overrun <= 1'b0;
  end

  assign head_data  = head_entry.data;
  assign head_brk   = head_entry.brk;
  assign head_fe    = head_entry.fe;
  assign head_pe    = head_entry.pe;
  assign data_ready = (occupancy != '0);
  assign trig_hit   = (32'(occupancy) >= trig_level(trig_sel, fifo_en));
endmodule

// File: rtl/uart_rxq_chk.sv
`timescale 1ns/1ps
module uart_rxq_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             push_valid,
  input logic             pop,
  input logic             rx_clear,
  input logic             lsr_read,
  input logic             data_ready,
  input logic             trig_hit,
  input logic             err_any,
  input logic             overrun,
  input logic             char_tout,
  input logic             head_brk,
  input logic             head_fe,
  input logic             head_pe,
  input logic [CNT_W-1:0] occupancy,
  input logic             drop,
  input logic             flush,
  input logic             pop_fire
);
  // R5
  single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !flush) |-> (occupancy <= 1));
  // R6
  depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));
  // R6
  drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun);
  // R7
  lsr_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_read && !drop) |=> !overrun);
  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clear |=> (!data_ready && !err_any && !char_tout));
  // R8
  head_err_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && (head_brk || head_fe || head_pe)) |-> err_any);
  // R4
  empty_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> !trig_hit);
  // R5
  single_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && data_ready) |-> trig_hit);
  // R12
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !data_ready && !push_valid) |=> !data_ready);
  // R11
  pop_clears_tout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> !char_tout);
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/uart_rxq_tb_top.sv
`timescale 1ns/1ps
module uart_rxq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 0, push_brk = 0, push_fe = 0, push_pe = 0;
  logic [7:0]  push_data = 0;
  logic        pop = 0, fifo_en = 0, rx_clear = 0, lsr_read = 0;
  logic [1:0]  trig_sel = 0;
  logic [15:0] tout_limit = 16'd4;
  logic [7:0]  head_data;
  logic        head_brk, head_fe, head_pe, data_ready, trig_hit, err_any, overrun, char_tout;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rxq dut_i (.*);

  // Reference state: entries packed as {brk, fe, pe, data}.
  logic [10:0] q[$];
  bit m_ovr, m_tout, m_en_prev;
  int m_tcnt;

  function automatic int lvl(input logic [1:0] s, input logic en);
    int tab[4] = '{1, 8, 16, 14};
    return en ? tab[s] : 1;
  endfunction

  function automatic bit any_err();
    foreach (q[i]) if (q[i][10:8] != 3'b000) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [10:0] hd = (q.size() != 0) ? q[0] : 11'd0;
    check("R2 head", {head_brk, head_fe, head_pe, head_data}, hd);
    check("R3 data_ready", data_ready, q.size() != 0);
    check("R4 R5 trig_hit", trig_hit, q.size() >= lvl(trig_sel, fifo_en));
    check("R8 err_any", err_any, any_err());
    check("R6 R7 overrun", overrun, m_ovr);
    check("R11 char_tout", char_tout, m_tout);
  endtask

  task automatic model_edge();
    int cap = fifo_en ? 64 : 1;
    int lim = (tout_limit == 0) ? 1 : tout_limit;
    bit fl = rx_clear || (fifo_en != m_en_prev);
    bit popf, acc, drp, idle;
    drp = 0;
    if (fl) begin
      q.delete(); m_tout = 0; m_tcnt = 0;
    end else begin
      popf = pop && q.size() != 0;
      acc  = push_valid && (q.size() < cap || popf);
      drp  = push_valid && !acc;
      idle = q.size() != 0 && !acc && !popf;
      if (popf) m_tout = 0;
      else if (idle && m_tcnt + 1 >= lim) m_tout = 1;
      m_tcnt = idle ? m_tcnt + 1 : 0;
      if (popf) void'(q.pop_front());
      if (acc) q.push_back({push_brk, push_fe, push_pe, push_data});
    end
    if (drp) m_ovr = 1;
    else if (lsr_read) m_ovr = 0;
    m_en_prev = fifo_en;
  endtask

  task automatic step(input bit pv, input logic [7:0] d, input logic [2:0] fl,
                      input bit pp, input bit clr, input bit lsr);
    @(negedge clk);
    push_valid = pv; push_data = d; {push_brk, push_fe, push_pe} = fl;
    pop = pp; rx_clear = clr; lsr_read = lsr;
    model_edge();
    @(posedge clk); #1;
    compare_all();
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #12;
    // R1: reset state
    check("R1 data_ready", data_ready, 0);
    check("R1 flags", {trig_hit, err_any, overrun, char_tout}, 0);
    check("R1 head", {head_brk, head_fe, head_pe, head_data}, 0);
    rst_n = 1;
    m_ovr = 0; m_tout = 0; m_en_prev = 0; m_tcnt = 0;

    // R4 R6: fill 64 with level 8, overflow, R7 clear by status read
    fifo_en = 1; trig_sel = 2'b01; tout_limit = 16'd200;
    idle_n(1);
    for (int i = 0; i < 65; i++) step(1, 8'(i + 3), 0, 0, 0, 0);
    check("R6 overrun after drop", overrun, 1);
    step(1, 8'hAA, 0, 1, 0, 0);       // R6: push+pop at capacity both act
    step(0, 0, 0, 0, 0, 1);           // R7
    check("R7 overrun cleared", overrun, 0);
    for (int s = 0; s < 4; s++) begin trig_sel = 2'(s); idle_n(1); end
    for (int i = 0; i < 66; i++) step(0, 0, 0, 1, 0, 0);   // R12 extra pops
    check("R12 empty after extra pops", data_ready, 0);

    // R8: error flag outlives clean entries ahead of it
    step(1, 8'h11, 3'b000, 0, 0, 0);
    step(1, 8'h22, 3'b010, 0, 0, 0);
    step(1, 8'h33, 3'b000, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    check("R8 err_any held", err_any, 1);
    step(0, 0, 0, 1, 0, 0);
    check("R8 err_any released", err_any, 0);

    // R11: timeout after exactly 4 idle cycles, clears on pop
    tout_limit = 16'd4;
    idle_n(3);
    check("R11 no early timeout", char_tout, 0);
    idle_n(1);
    check("R11 timeout raised", char_tout, 1);
    step(0, 0, 0, 1, 0, 0);
    check("R11 cleared by pop", char_tout, 0);

    // R9: clear beats a same-cycle push
    step(1, 8'h44, 3'b100, 0, 0, 0);
    step(1, 8'h55, 0, 0, 1, 0);
    check("R9 empty after clear", data_ready, 0);

    // R10 R5: mode change flushes; single register holds one
    step(1, 8'h66, 0, 0, 0, 0);
    fifo_en = 0; idle_n(1);
    check("R10 flushed on mode change", data_ready, 0);
    step(1, 8'h77, 3'b001, 0, 0, 0);
    step(1, 8'h78, 0, 0, 0, 0);
    check("R5 single register overrun", overrun, 1);
    step(1, 8'h79, 0, 1, 0, 1);
    tout_limit = 0; idle_n(2);        // R11 limit 0 acts as 1

    // Random phases
    for (int ph = 0; ph < 8; ph++) begin
      int pw = 20 + 10 * ph;
      fifo_en = (ph % 4) != 3;
      trig_sel = 2'($urandom_range(0, 3));
      tout_limit = 16'($urandom_range(0, 6));
      for (int i = 0; i < 700; i++) begin
        int r = $urandom_range(0, 99);
        logic [2:0] f = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
        step(r < pw, 8'($urandom), f, $urandom_range(0, 99) < (ph % 2 ? 35 : 60),
             $urandom_range(0, 299) == 0, $urandom_range(0, 19) == 0);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule